// File: doc/BRIEF.md
# Multi-drop JTAG gateway selection logic

This block decides whether one gateway on a shared backplane JTAG bus answers the host. It has its own 16-state TAP controller and an 8-bit instruction register. While the gateway is waiting to be chosen, every Update-IR compares the shifted code against a 6-bit slot address strapped on pins. A code can address one slot, or every gateway at once (broadcast), or every gateway whose 2-bit group register holds a given value (multicast group).

Only a gateway chosen by its own single address drives the primary TDO. Gateways chosen by broadcast or by group take the scans with their TDO in high impedance, so two drivers never meet on the shared TDO line. A gateway whose compare fails becomes unselected. It stays unselected until it gets the release opcode 0xC3 or a reset. The release opcode also sends a selected gateway back to waiting. An active-low selected output and an active-low local-port enable report the selection to the board. Both are registered on the falling edge of TCK, together with TDO.

Top module: `mdrop_select`

## Requirements
- R1: After TRST low, both active-low outputs `sel_n` and `port_en_n` read 1 and `tdo_en` reads 0.
- R2: Waiting, an Update-IR with code bits [5:0] in 0x00..0x3A equal to `slot_addr` selects the gateway. Bits [7:6] are ignored. `tdo_en` is 1 during Shift-IR and Shift-DR while selected this way.
- R3: Waiting, an Update-IR with code bits [5:0] in 0x00..0x3A that differ from `slot_addr` makes the gateway unselected. `sel_n` reads 1 and `tdo_en` stays 0.
- R4: Waiting, code bits [5:0] = 0x3B (broadcast) select the gateway with `sel_n`=0 and `tdo_en` held at 0.
- R5: Waiting, code bits [5:0] = 0x3C+g (g = 0..3) select the gateway when its group register equals g, with `tdo_en` held at 0. Any other g makes it unselected.
- R6: An unselected gateway ignores address codes, including its own slot. Only opcode 0xC3 or a reset returns it to waiting.
- R7: In any selected mode, opcode 0xC3 returns the gateway to waiting, so `sel_n` reads 1.
- R8: Selected, opcode 0x03 puts the 2-bit group register in the DR path, LSB first. Capture-DR loads the current value and Update-DR writes the shifted value.
- R9: The group register clears to 00 and selection returns to waiting on TRST, on entering Test-Logic-Reset (five TCK with TMS high), and on `port_rst_n` low.
- R10: `sel_n` and `port_en_n` change only on a falling TCK edge, one half cycle after the rising edge that takes the decision.
- R11: While waiting or unselected, DR scans and instructions leave the group register unchanged.
- R12: Selected, Capture-IR loads 0x01. Opcodes other than 0x03 and 0xC3 put a 1-bit bypass register, captured as 0, in the DR path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| port_rst_n | input | 1 | Local-port reset pin, active low, asynchronous |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| slot_addr | input | 6 | Backplane slot address straps |
| tdo | output | 1 | Test data out value |
| tdo_en | output | 1 | TDO drive enable (0 = high impedance) |
| sel_n | output | 1 | Gateway selected, active low |
| port_en_n | output | 1 | Local-port enable, active low |

## Verification
The hardest states to reach are an unselected gateway and a gateway chosen only by group. Neither drives TDO, so neither can report its internal state. The stimulus pushes the gateway into these states, then scans in a release code and its own single address. Once selected this way it drives TDO, and reading its group register back shows whether the earlier scans changed it. The same route shows which group value a Test-Logic-Reset or a write left behind. A bit-level scan around Update-IR checks the half-cycle timing of `sel_n`.

// File: rtl/mds_pkg.sv
package mds_pkg;
  localparam int IR_W   = 8;
  localparam int ADDR_W = 6;
  localparam int GRP_W  = 2;
  localparam int TAP_W  = 4;

  localparam logic [ADDR_W-1:0] LAST_SINGLE = 6'h3A;
  localparam logic [ADDR_W-1:0] BCAST_CODE  = 6'h3B;
  localparam logic [ADDR_W-1:0] GROUP_BASE  = 6'h3C;
  localparam logic [IR_W-1:0]   OP_RELEASE  = 8'hC3;
  localparam logic [IR_W-1:0]   OP_GROUPREG = 8'h03;
  localparam logic [IR_W-1:0]   OP_BYPASS   = 8'hFF;
  localparam logic [IR_W-1:0]   IR_CAPTURE  = 8'h01;

  typedef enum logic [TAP_W-1:0] {
    T_RESET, T_IDLE, T_SEL_DR, T_CAP_DR, T_SHF_DR, T_EX1_DR, T_PAU_DR, T_EX2_DR, T_UPD_DR,
    T_SEL_IR, T_CAP_IR, T_SHF_IR, T_EX1_IR, T_PAU_IR, T_EX2_IR, T_UPD_IR
  } tap_st_t;

  typedef enum logic [2:0] {
    S_WAIT, S_SINGLE, S_BCAST, S_GROUP, S_UNSEL
  } sel_st_t;

  typedef enum logic [1:0] {
    K_SINGLE, K_BCAST, K_GROUP
  } addr_kind_t;

  function automatic tap_st_t tap_next(input tap_st_t s, input logic m);
    case (s)
      T_RESET:  tap_next = m ? T_RESET  : T_IDLE;
      T_IDLE:   tap_next = m ? T_SEL_DR : T_IDLE;
      T_SEL_DR: tap_next = m ? T_SEL_IR : T_CAP_DR;
      T_CAP_DR: tap_next = m ? T_EX1_DR : T_SHF_DR;
      T_SHF_DR: tap_next = m ? T_EX1_DR : T_SHF_DR;
      T_EX1_DR: tap_next = m ? T_UPD_DR : T_PAU_DR;
      T_PAU_DR: tap_next = m ? T_EX2_DR : T_PAU_DR;
      T_EX2_DR: tap_next = m ? T_UPD_DR : T_SHF_DR;
      T_UPD_DR: tap_next = m ? T_SEL_DR : T_IDLE;
      T_SEL_IR: tap_next = m ? T_RESET  : T_CAP_IR;
      T_CAP_IR: tap_next = m ? T_EX1_IR : T_SHF_IR;
      T_SHF_IR: tap_next = m ? T_EX1_IR : T_SHF_IR;
      T_EX1_IR: tap_next = m ? T_UPD_IR : T_PAU_IR;
      T_PAU_IR: tap_next = m ? T_EX2_IR : T_PAU_IR;
      T_EX2_IR: tap_next = m ? T_UPD_IR : T_SHF_IR;
      default:  tap_next = m ? T_SEL_DR : T_IDLE;
    endcase
  endfunction

  function automatic addr_kind_t addr_kind(input logic [IR_W-1:0] code);
    logic [ADDR_W-1:0] a;
    a = code[ADDR_W-1:0];
    if (a <= LAST_SINGLE)      addr_kind = K_SINGLE;
    else if (a == BCAST_CODE)  addr_kind = K_BCAST;
    else                       addr_kind = K_GROUP;
  endfunction

  function automatic logic [GRP_W-1:0] group_of(input logic [IR_W-1:0] code);
    logic [ADDR_W-1:0] d;
    d = code[ADDR_W-1:0] - GROUP_BASE;
    group_of = d[GRP_W-1:0];
  endfunction

  function automatic logic is_sel(input sel_st_t s);
    is_sel = (s == S_SINGLE) || (s == S_BCAST) || (s == S_GROUP);
  endfunction
endpackage

// File: rtl/mds_tap.sv
module mds_tap
  import mds_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_t st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= T_RESET;
    else        st <= tap_next(st, tms);
  end

  a_r9_five_ones_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (st == T_RESET));
endmodule

// File: rtl/mds_ir.sv
module mds_ir
  import mds_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  tap_st_t         st,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sh,
  output logic            ir_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_sh <= IR_CAPTURE;
    else if (st == T_CAP_IR) ir_sh <= IR_CAPTURE;
    else if (st == T_SHF_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end
  assign ir_out = ir_sh[0];

  a_r12_capture_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_CAP_IR) |=> (ir_sh == IR_CAPTURE));
endmodule

// File: rtl/mds_selfsm.sv
module mds_selfsm
  import mds_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tap_st_t           st,
  input  logic [IR_W-1:0]   ir_sh,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic [GRP_W-1:0]  grp,
  output sel_st_t           sel_st,
  output logic [IR_W-1:0]   instr
);
  logic upd_ir, in_tlr, hit_single, hit_group, is_release;
  addr_kind_t kind;
  sel_st_t nxt;

  assign upd_ir     = (st == T_UPD_IR);
  assign in_tlr     = (st == T_RESET);
  assign kind       = addr_kind(ir_sh);
  assign hit_single = (ir_sh[ADDR_W-1:0] == slot_addr);
  assign hit_group  = (group_of(ir_sh) == grp);
  assign is_release = (ir_sh == OP_RELEASE);

  always_comb begin
    nxt = sel_st;
    if (upd_ir) begin
      case (sel_st)
        S_WAIT: begin
          case (kind)
            K_SINGLE: nxt = hit_single ? S_SINGLE : S_UNSEL;
            K_BCAST:  nxt = S_BCAST;
            default:  nxt = hit_group ? S_GROUP : S_UNSEL;
          endcase
        end
        default: if (is_release) nxt = S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_st <= S_WAIT;
      instr  <= OP_BYPASS;
    end else if (in_tlr) begin
      sel_st <= S_WAIT;
      instr  <= OP_BYPASS;
    end else begin
      sel_st <= nxt;
      if (upd_ir && is_sel(sel_st) && !is_release) instr <= ir_sh;
      else if (upd_ir) instr <= OP_BYPASS;
    end
  end

  a_r3_mismatch_unsel: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ir && sel_st == S_WAIT && ir_sh[ADDR_W-1:0] <= LAST_SINGLE &&
     ir_sh[ADDR_W-1:0] != slot_addr) |=> (sel_st == S_UNSEL));
  a_r4_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ir && sel_st == S_WAIT && ir_sh[ADDR_W-1:0] == BCAST_CODE) |=> (sel_st == S_BCAST));
  a_r6_unsel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_st == S_UNSEL && !in_tlr && !(upd_ir && ir_sh == OP_RELEASE)) |=> (sel_st == S_UNSEL));
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ir && sel_st != S_WAIT && ir_sh == OP_RELEASE) |=> (sel_st == S_WAIT));
endmodule

// File: rtl/mds_dr.sv
module mds_dr
  import mds_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tap_st_t          st,
  input  logic             tdi,
  input  logic [IR_W-1:0]  instr,
  input  logic             active,
  output logic [GRP_W-1:0] grp,
  output logic             dr_out
);
  logic [GRP_W-1:0] grp_sh;
  logic byp, grp_path, upd_dr;

  assign grp_path = active && (instr == OP_GROUPREG);
  assign upd_dr   = (st == T_UPD_DR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp    <= '0;
      grp_sh <= '0;
      byp    <= 1'b0;
    end else if (st == T_RESET) begin
      grp    <= '0;
      grp_sh <= '0;
      byp    <= 1'b0;
    end else begin
      if (st == T_CAP_DR) begin
        grp_sh <= grp;
        byp    <= 1'b0;
      end else if (st == T_SHF_DR) begin
        grp_sh <= {tdi, grp_sh[GRP_W-1:1]};
        byp    <= tdi;
      end
      if (upd_dr && grp_path) grp <= grp_sh;
    end
  end

  assign dr_out = grp_path ? grp_sh[0] : byp;

  a_r8_group_write: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_dr && grp_path) |=> (grp == $past(grp_sh)));
  a_r11_group_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && st != T_RESET) |=> $stable(grp));
endmodule

// File: rtl/mdrop_select.sv
module mdrop_select
  import mds_pkg::*;
(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              port_rst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              tdo,
  output logic              tdo_en,
  output logic              sel_n,
  output logic              port_en_n
);
  logic             rst_n;
  tap_st_t          st;
  logic [IR_W-1:0]  ir_sh, instr;
  logic             ir_out, dr_out, active, drives;
  logic [GRP_W-1:0] grp;
  sel_st_t          sel_st;

  assign rst_n = trst_n & port_rst_n;

  mds_tap u_tap (.clk(tck), .rst_n(rst_n), .tms(tms), .st(st));
  mds_ir u_ir (.clk(tck), .rst_n(rst_n), .st(st), .tdi(tdi), .ir_sh(ir_sh), .ir_out(ir_out));
  mds_selfsm u_sel (.clk(tck), .rst_n(rst_n), .st(st), .ir_sh(ir_sh), .slot_addr(slot_addr),
                    .grp(grp), .sel_st(sel_st), .instr(instr));
  mds_dr u_dr (.clk(tck), .rst_n(rst_n), .st(st), .tdi(tdi), .instr(instr), .active(active),
               .grp(grp), .dr_out(dr_out));

  assign active = is_sel(sel_st);
  assign drives = (sel_st == S_SINGLE) && (st == T_SHF_IR || st == T_SHF_DR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo       <= 1'b1;
      tdo_en    <= 1'b0;
      sel_n     <= 1'b1;
      port_en_n <= 1'b1;
    end else begin
      if (st == T_SHF_IR)      tdo <= ir_out;
      else if (st == T_SHF_DR) tdo <= dr_out;
      tdo_en    <= drives;
      sel_n     <= !active;
      port_en_n <= !active;
    end
  end

  a_r10_sel_tracks_state: assert property (@(posedge tck) disable iff (!rst_n)
    sel_n == !is_sel(sel_st));
  a_r2_only_single_drives: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (sel_st == S_SINGLE));
  a_r10_pins_agree: assert property (@(posedge tck) disable iff (!rst_n)
    sel_n == port_en_n);
endmodule

// File: tb/sim_mdrop_select.sv
module sim_mdrop_select;
  logic tck = 1'b0;
  logic trst_n = 1'b0, port_rst_n = 1'b1, tms = 1'b1, tdi = 1'b0;
  logic [5:0] slot_addr = 6'h05;
  logic tdo, tdo_en, sel_n, port_en_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 tck = ~tck;

  mdrop_select u0 (.tck(tck), .trst_n(trst_n), .port_rst_n(port_rst_n), .tms(tms), .tdi(tdi),
                   .slot_addr(slot_addr), .tdo(tdo), .tdo_en(tdo_en), .sel_n(sel_n),
                   .port_en_n(port_en_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic pulse_trst();
    trst_n = 1'b0; #5; trst_n = 1'b1;
    @(negedge tck); #1;
    tick(1'b0, 1'b0);
  endtask

  // from Idle to Update-IR; returns bits seen on tdo and whether tdo_en was ever high
  task automatic ir_to_update(input logic [7:0] code, output logic [7:0] seen, output logic en);
    en = 1'b0;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 8; i++) begin
      seen[i] = tdo; en = en | tdo_en;
      tick(i == 7, code[i]);
    end
    tick(1, 0);
  endtask

  task automatic scan_ir(input logic [7:0] code, output logic [7:0] seen, output logic en);
    ir_to_update(code, seen, en);
    tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [7:0] data, output logic [7:0] seen);
    seen = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      seen[i] = tdo;
      tick(i == n - 1, data[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  // slot, code, expected sel_n, expected tdo_en during a following IR scan
  localparam logic [15:0] VEC [8] = '{
    {6'h05, 8'h05, 1'b0, 1'b1},  // R2 match
    {6'h05, 8'hC5, 1'b0, 1'b1},  // R2 top bits ignored
    {6'h05, 8'h06, 1'b1, 1'b0},  // R3 mismatch
    {6'h3A, 8'h3A, 1'b0, 1'b1},  // R2 highest single code
    {6'h00, 8'h3B, 1'b0, 1'b0},  // R4 broadcast
    {6'h12, 8'h3C, 1'b0, 1'b0},  // R5 group 0 hit
    {6'h12, 8'h3D, 1'b1, 1'b0},  // R5 group 1 miss
    {6'h00, 8'h40, 1'b0, 1'b1}   // R2 slot 0 via top bits set
  };

  initial begin
    logic [7:0] seen;
    logic en;
    #3; trst_n = 1'b1;
    @(negedge tck); #1;
    // R1 reset state
    check("R1 sel_n", sel_n, 1); check("R1 port_en_n", port_en_n, 1); check("R1 tdo_en", tdo_en, 0);
    tick(0, 0);

    for (int v = 0; v < 8; v++) begin
      slot_addr = VEC[v][15:10];
      pulse_trst();
      scan_ir(VEC[v][9:2], seen, en);
      check("R2/R3/R4/R5 sel_n", sel_n, VEC[v][1]);
      check("R2/R3/R4/R5 port_en_n", port_en_n, VEC[v][1]);
      scan_ir(8'hFF, seen, en);
      check("R2/R4/R5 tdo_en", en, VEC[v][0]);
    end

    // R6 unselected is sticky
    slot_addr = 6'h05; pulse_trst();
    scan_ir(8'h06, seen, en);
    scan_ir(8'h05, seen, en);
    check("R6 own slot ignored", sel_n, 1);
    scan_ir(8'hC3, seen, en);
    scan_ir(8'h05, seen, en);
    check("R6 release then select", sel_n, 0);

    // R12 IR capture and bypass
    scan_ir(8'hFF, seen, en);
    check("R12 IR capture", seen, 8'h01);
    scan_dr(4, 8'b1011, seen);
    check("R12 bypass delay", seen, 8'b0110);

    // R8 group register write and readback
    scan_ir(8'h03, seen, en);
    scan_dr(2, 8'b10, seen);
    check("R8 group capture after reset", seen, 8'b00);
    scan_dr(2, 8'b10, seen);
    check("R8 group readback", seen, 8'b10);

    // R7 release, R5 group 2 hit, group 1 miss
    scan_ir(8'hC3, seen, en);
    check("R7 release", sel_n, 1);
    scan_ir(8'h3E, seen, en);
    check("R5 group 2 hit", sel_n, 0);
    scan_ir(8'hC3, seen, en);
    scan_ir(8'h3D, seen, en);
    check("R5 group 1 miss", sel_n, 1);

    // R9 TMS reset clears selection and group
    scan_ir(8'hC3, seen, en);
    scan_ir(8'h05, seen, en);
    scan_ir(8'h03, seen, en);
    scan_dr(2, 8'b11, seen);
    for (int k = 0; k < 5; k++) tick(1, 0);
    tick(0, 0);
    check("R9 TLR deselect", sel_n, 1);
    scan_ir(8'h05, seen, en);
    scan_ir(8'h03, seen, en);
    scan_dr(2, 8'b11, seen);
    check("R9 group cleared by TLR", seen, 8'b00);

    // R11 unselected scans leave group (now 11) alone
    scan_ir(8'hC3, seen, en);
    scan_ir(8'h07, seen, en);
    scan_dr(2, 8'b00, seen);
    scan_ir(8'h03, seen, en);
    scan_dr(2, 8'b00, seen);
    scan_ir(8'hC3, seen, en);
    scan_dr(2, 8'b00, seen);
    scan_ir(8'h05, seen, en);
    scan_ir(8'h03, seen, en);
    scan_dr(2, 8'b00, seen);
    check("R11 group unchanged", seen, 8'b11);

    // R9 port reset pin
    port_rst_n = 1'b0; #3;
    check("R9 port reset sel_n", sel_n, 1);
    check("R9 port reset port_en_n", port_en_n, 1);
    port_rst_n = 1'b1;
    @(negedge tck); #1; tick(0, 0);

    // R10 falling-edge timing
    ir_to_update(8'h05, seen, en);
    tms = 1'b0;
    @(posedge tck); #1;
    check("R10 unchanged after rising edge", sel_n, 1);
    @(negedge tck); #1;
    check("R10 changed at falling edge", sel_n, 0);
    check("R10 port_en_n follows", port_en_n, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule